// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block picks a victim among a table of page frames using the clock (second-chance) policy. It holds one used bit and one dirty bit for each frame. Reference inputs set the used bit, and a reference marked as a write also sets the dirty bit. A circular hand remembers where the last selection stopped.

A replacement request starts a sweep. The sweep examines one frame per clock, starting at the hand. It clears the used bit of every frame it passes and stops at the first frame whose used bit is already clear. When the request asks for clean frames, the sweep looks for a frame that is both unused and not dirty, for at most two full passes. If it finds none, it returns the first unused frame it met and reports that this victim is dirty.

The caller sees a one-cycle done pulse together with the victim index and its dirty flag. Evicting the page, writing it back and refilling the frame are the caller's job.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every used bit and every dirty bit is 0, the hand is 0, and busy and done are 0.
- R2: A reference (ref_valid=1) sets the used bit of frame ref_idx on the next edge. With ref_write=1 it also sets that frame's dirty bit. A reference with ref_write=0 leaves the dirty bit unchanged. Dirty bits are never cleared except by reset.
- R3: With prefer_clean=0 the victim is the first frame, walking upward from the hand and wrapping at N-1 back to 0, whose used bit is 0 when examined. Every frame passed before it has its used bit cleared.
- R4: The sweep examines exactly one frame per cycle. When the victim is the k-th frame examined, done is high for exactly one cycle, k cycles after the cycle in which the request was accepted. With no references during the sweep, a plain sweep has k ≤ N+1.
- R5: After a selection the hand points one past the victim, modulo N.
- R6: With prefer_clean=1 the victim is the first frame from the hand that is both unused and clean, searched over at most 2N examinations. victim_dirty is 0 in that case.
- R7: If 2N examinations in clean-preferring mode find no unused clean frame, the victim is the first unused frame met during the sweep. victim_dirty is 1, and done comes after exactly 2N examinations.
- R8: A reference to the frame being examined in the same cycle wins: that frame keeps its used bit set and is not chosen in that step.
- R9: A request arriving while a sweep is in progress is ignored. It starts no second sweep and produces no extra done pulse.
- R10: With prefer_clean=0, victim_dirty equals the dirty bit of the chosen frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | 1 | Frame reference strobe |
| ref_idx | input | IW | Referenced frame |
| ref_write | input | 1 | Reference is a write (sets dirty) |
| req_valid | input | 1 | Request a victim (accepted when idle) |
| prefer_clean | input | 1 | 1: prefer unused and clean frames |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse: victim is valid |
| victim_idx | output | IW | Chosen frame |
| victim_dirty | output | 1 | Chosen frame is dirty |
| hand_idx | output | IW | Current clock hand |
| used_vec | output | N | Used bits, bit i for frame i |
| dirty_vec | output | N | Dirty bits, bit i for frame i |

## Verification
Two functions can fall in the same cycle: a reference and a sweep step on the same frame. Whichever of them wins decides whether that frame is skipped and keeps its used bit. The bench provokes this collision directly. It clears the used bit of only frame 0, sits the hand there, and references frame 0 in exactly the cycle the sweep examines it. The bench then judges the outcome by the victim index, the number of cycles until done and the used bits afterwards, all of which differ if the sweep step had won. A request pulsed in the middle of a long sweep checks that a second request is dropped.

// File: rtl/clock_sel_pkg.sv
// Shared types for the clock victim selector.
package clock_sel_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;
endpackage

// File: rtl/clock_frame_table.sv
// Per-frame used and dirty bits.
// Assumes: at most one reference and one sweep clear per cycle.
// A reference beats a clear on the same frame.
module clock_frame_table #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_valid,
    input  logic [IW-1:0] ref_idx,
    input  logic          ref_write,
    input  logic          clr_valid,
    input  logic [IW-1:0] clr_idx,
    output logic [N-1:0]  used_vec,
    output logic [N-1:0]  dirty_vec
);
    for (genvar g = 0; g < N; g++) begin : g_frame
        logic hit_ref;
        logic hit_clr;
        assign hit_ref = ref_valid && (ref_idx == IW'(g));
        assign hit_clr = clr_valid && (clr_idx == IW'(g));

        // Used bit: set by a reference, cleared by the sweep, reference first.
        always_ff @(posedge clk) begin
            if (!rst_n)       used_vec[g] <= 1'b0;
            else if (hit_ref) used_vec[g] <= 1'b1;
            else if (hit_clr) used_vec[g] <= 1'b0;
        end

        // Dirty bit: sticky once written.
        always_ff @(posedge clk) begin
            if (!rst_n)                     dirty_vec[g] <= 1'b0;
            else if (hit_ref && ref_write)  dirty_vec[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/clock_hand.sv
// Circular pointer over N frames.
// A load places the hand one past the loaded index; an advance steps it by one.
module clock_hand #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          load,
    input  logic [IW-1:0] load_idx,
    output logic [IW-1:0] hand
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] v);
        return (v == LAST) ? '0 : v + 1'b1;
    endfunction

    // Hand register: load takes priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n)    hand <= '0;
        else if (load) hand <= wrap_inc(load_idx);
        else if (adv)  hand <= wrap_inc(hand);
    end
endmodule

// File: rtl/clock_sweep_ctrl.sv
// Sweep controller. It examines the frame under the hand once per cycle and
// clears passed used bits. In clean-preferring mode it records a fallback
// frame and ends after 2N examinations. Assumes the frame table applies a
// reference ahead of a clear.
module clock_sweep_ctrl
    import clock_sel_pkg::*;
#(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          prefer_clean,
    input  logic          ref_valid,
    input  logic [IW-1:0] ref_idx,
    input  logic [IW-1:0] hand,
    input  logic [N-1:0]  used_vec,
    input  logic [N-1:0]  dirty_vec,
    output logic          adv,
    output logic          load,
    output logic [IW-1:0] load_idx,
    output logic          clr_valid,
    output logic [IW-1:0] clr_idx,
    output logic          busy,
    output logic          done,
    output logic [IW-1:0] victim_idx,
    output logic          victim_dirty
);
    localparam int CW = $clog2(2 * N + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(2 * N - 1);

    scan_state_e   state;
    logic          mode_clean;
    logic          fb_only;
    logic          fb_valid;
    logic [IW-1:0] fb_idx;
    logic [CW-1:0] step_cnt;

    logic          ref_hit, cur_used, cur_dirty, scanning;
    logic          pick_cur, last_step, finish, fin_dirty, take_fb_here;
    logic [IW-1:0] fin_idx;

    // Examine the frame under the hand.
    always_comb begin
        scanning     = (state == ST_SCAN);
        ref_hit      = ref_valid && (ref_idx == hand);
        cur_used     = used_vec[hand] || ref_hit;
        cur_dirty    = dirty_vec[hand];
        pick_cur     = 1'b0;
        if (scanning) begin
            if (mode_clean && !fb_only) pick_cur = !cur_used && !cur_dirty;
            else                        pick_cur = !cur_used;
        end
        last_step    = scanning && mode_clean && !fb_only && (step_cnt == LAST_STEP);
        take_fb_here = !fb_valid && !cur_used;
        finish       = 1'b0;
        fin_idx      = hand;
        fin_dirty    = cur_dirty;
        if (pick_cur) begin
            finish = 1'b1;
        end else if (last_step && fb_valid) begin
            finish    = 1'b1;
            fin_idx   = fb_idx;
            fin_dirty = dirty_vec[fb_idx];
        end else if (last_step && take_fb_here) begin
            finish = 1'b1;
        end
    end

    // Drive the hand and the used-bit clear.
    always_comb begin
        load      = finish;
        load_idx  = fin_idx;
        adv       = scanning && !finish;
        clr_valid = scanning && !ref_hit && !(finish && fin_idx == hand);
        clr_idx   = hand;
    end

    // Sweep state, step count and fallback record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            mode_clean <= 1'b0;
            fb_only    <= 1'b0;
            fb_valid   <= 1'b0;
            fb_idx     <= '0;
            step_cnt   <= '0;
        end else if (state == ST_IDLE) begin
            if (req_valid) begin
                state      <= ST_SCAN;
                mode_clean <= prefer_clean;
                fb_only    <= 1'b0;
                fb_valid   <= 1'b0;
                step_cnt   <= '0;
            end
        end else begin
            if (finish) begin
                state <= ST_IDLE;
            end else begin
                if (step_cnt != LAST_STEP) step_cnt <= step_cnt + 1'b1;
                if (last_step) fb_only <= 1'b1;
                if (mode_clean && take_fb_here) begin
                    fb_valid <= 1'b1;
                    fb_idx   <= hand;
                end
            end
        end
    end

    // Result registers and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done         <= 1'b0;
            victim_idx   <= '0;
            victim_dirty <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                victim_idx   <= fin_idx;
                victim_dirty <= fin_dirty;
            end
        end
    end

    assign busy = scanning;
endmodule

// File: rtl/clock_victim_sel.sv
// Top: clock page replacement selector. Joins the frame table, the hand
// and the sweep controller. Assumes N >= 2.
module clock_victim_sel #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_valid,
    input  logic [IW-1:0] ref_idx,
    input  logic          ref_write,
    input  logic          req_valid,
    input  logic          prefer_clean,
    output logic          busy,
    output logic          done,
    output logic [IW-1:0] victim_idx,
    output logic          victim_dirty,
    output logic [IW-1:0] hand_idx,
    output logic [N-1:0]  used_vec,
    output logic [N-1:0]  dirty_vec
);
    logic          adv, load, clr_valid;
    logic [IW-1:0] load_idx, clr_idx;

    clock_frame_table #(.N(N), .IW(IW)) u_table (
        .clk(clk), .rst_n(rst_n),
        .ref_valid(ref_valid), .ref_idx(ref_idx), .ref_write(ref_write),
        .clr_valid(clr_valid), .clr_idx(clr_idx),
        .used_vec(used_vec), .dirty_vec(dirty_vec)
    );

    clock_hand #(.N(N), .IW(IW)) u_hand (
        .clk(clk), .rst_n(rst_n),
        .adv(adv), .load(load), .load_idx(load_idx), .hand(hand_idx)
    );

    clock_sweep_ctrl #(.N(N), .IW(IW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .prefer_clean(prefer_clean),
        .ref_valid(ref_valid), .ref_idx(ref_idx),
        .hand(hand_idx), .used_vec(used_vec), .dirty_vec(dirty_vec),
        .adv(adv), .load(load), .load_idx(load_idx),
        .clr_valid(clr_valid), .clr_idx(clr_idx),
        .busy(busy), .done(done),
        .victim_idx(victim_idx), .victim_dirty(victim_dirty)
    );
endmodule

// File: rtl/clock_victim_sel_chk.sv
// Property checker for clock_victim_sel, attached by bind.
module clock_victim_sel_chk #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ref_valid,
    input logic [IW-1:0] ref_idx,
    input logic          ref_write,
    input logic          req_valid,
    input logic          busy,
    input logic          done,
    input logic [IW-1:0] victim_idx,
    input logic [IW-1:0] hand_idx,
    input logic [N-1:0]  used_vec,
    input logic [N-1:0]  dirty_vec
);
    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] v);
        return (v == IW'(N - 1)) ? '0 : v + 1'b1;
    endfunction

    p_ref_sets_used_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> used_vec[$past(ref_idx)]);

    p_write_sets_dirty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_write) |=> dirty_vec[$past(ref_idx)]);

    p_dirty_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((dirty_vec & $past(dirty_vec)) == $past(dirty_vec)));

    p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> (hand_idx == nxt($past(hand_idx))));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hand_past_victim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hand_idx == nxt(victim_idx)));

    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && !done) |=> !done || !busy);
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.N(N), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_idx(ref_idx),
    .ref_write(ref_write), .req_valid(req_valid), .busy(busy), .done(done),
    .victim_idx(victim_idx), .hand_idx(hand_idx),
    .used_vec(used_vec), .dirty_vec(dirty_vec)
);

// File: tb/clock_victim_sel_tb.sv
module clock_victim_sel_tb;
    localparam int N  = 16;
    localparam int IW = $clog2(N);

    logic clk = 1'b0, rst_n = 1'b0;
    logic ref_valid = 0, ref_write = 0, req_valid = 0, prefer_clean = 0;
    logic [IW-1:0] ref_idx = '0;
    logic busy, done, victim_dirty;
    logic [IW-1:0] victim_idx, hand_idx;
    logic [N-1:0] used_vec, dirty_vec;

    int checks = 0, errors = 0;
    logic [N-1:0] m_used, m_dirty;
    int m_hand;
    int e_victim, e_steps;
    bit e_dirty;

    always #10 clk = ~clk;

    clock_victim_sel #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_idx(ref_idx),
        .ref_write(ref_write), .req_valid(req_valid), .prefer_clean(prefer_clean),
        .busy(busy), .done(done), .victim_idx(victim_idx),
        .victim_dirty(victim_dirty), .hand_idx(hand_idx),
        .used_vec(used_vec), .dirty_vec(dirty_vec)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        m_used = '0; m_dirty = '0; m_hand = 0;
    endtask

    task automatic do_ref(input int idx, input bit wr);
        @(negedge clk);
        ref_valid = 1; ref_idx = IW'(idx); ref_write = wr;
        @(negedge clk);
        ref_valid = 0; ref_write = 0;
        m_used[idx] = 1'b1;
        if (wr) m_dirty[idx] = 1'b1;
    endtask

    // Expected sweep result, built from the requirements (R3, R6, R7).
    task automatic model_sweep(input bit clean);
        int h; bit fbv; int fbi; bit fbo;
        h = m_hand; fbv = 0; fbi = 0; fbo = 0;
        for (int s = 0; s < 4 * N; s++) begin
            bit pick;
            pick = clean && !fbo ? (!m_used[h] && !m_dirty[h]) : !m_used[h];
            if (pick) begin
                e_victim = h; e_dirty = m_dirty[h]; e_steps = s + 1; break;
            end
            if (clean && !fbo && !fbv && !m_used[h]) begin fbv = 1; fbi = h; end
            m_used[h] = 1'b0;
            if (clean && !fbo && s == 2 * N - 1) begin
                if (fbv) begin e_victim = fbi; e_dirty = 1; e_steps = s + 1; break; end
                fbo = 1;
            end
            h = (h + 1) % N;
        end
        m_hand = (e_victim + 1) % N;
    endtask

    // Issue a request and count cycles to done; returns -1 on timeout.
    task automatic run_req(input bit clean, output int cyc);
        @(negedge clk);
        req_valid = 1; prefer_clean = clean;
        @(negedge clk);
        req_valid = 0;
        cyc = 0;
        do begin
            @(negedge clk); cyc++;
        end while (!done && cyc < 4 * N + 4);
        if (!done) cyc = -1;
    endtask

    task automatic check_result(input string tag, input int cyc);
        chk({tag, " victim"}, victim_idx, e_victim);
        chk({tag, " dirty"}, victim_dirty, e_dirty);
        chk({tag, " cycles"}, cyc, e_steps);
        chk({tag, " hand R5"}, hand_idx, m_hand);
        chk({tag, " used"}, used_vec, m_used);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        void'($urandom(32'h5eed_c10c));
        do_reset();
        // R1 reset state
        @(negedge clk);
        chk("R1 used", used_vec, 0);
        chk("R1 dirty", dirty_vec, 0);
        chk("R1 hand", hand_idx, 0);
        chk("R1 busy/done", {busy, done}, 0);

        // R2: read sets used only, write sets dirty
        do_ref(3, 0);
        chk("R2 read used", used_vec, m_used);
        chk("R2 read dirty", dirty_vec, 0);
        do_ref(5, 1);
        chk("R2 write dirty", dirty_vec, m_dirty);
        do_ref(5, 0);
        chk("R2 dirty sticky", dirty_vec, m_dirty);

        // R3/R4 plain: all used -> wraps, N+1 steps
        do_reset();
        for (int i = 0; i < N; i++) do_ref(i, i == 0);
        model_sweep(0);
        run_req(0, cyc);
        check_result("R3 R4 R10 all-used", cyc);

        // R7 fallback: every frame used and dirty
        do_reset();
        for (int i = 0; i < N; i++) do_ref(i, 1);
        model_sweep(1);
        @(negedge clk);
        req_valid = 1; prefer_clean = 1;
        @(negedge clk);
        req_valid = 0; cyc = 0;
        // R9: extra request mid-sweep
        repeat (5) begin @(negedge clk); cyc++; end
        req_valid = 1;
        @(negedge clk); cyc++;
        req_valid = 0;
        while (!done && cyc < 4 * N + 4) begin @(negedge clk); cyc++; end
        check_result("R7 fallback", cyc);
        repeat (3) begin
            @(negedge clk);
            chk("R9 no second sweep", {busy, done}, 0);
        end
        chk("R9 hand still", hand_idx, m_hand);

        // R8: reference collides with the examination of frame 0
        do_reset();
        for (int i = 1; i < N; i++) do_ref(i, 0);
        @(negedge clk);
        req_valid = 1; prefer_clean = 0;
        @(negedge clk);
        req_valid = 0; ref_valid = 1; ref_idx = '0; ref_write = 0;
        cyc = 0;
        do begin
            @(negedge clk); cyc++;
            ref_valid = 0;
        end while (!done && cyc < 4 * N + 4);
        chk("R8 victim", victim_idx, 1);
        chk("R8 cycles", cyc, N + 2);
        chk("R8 used", used_vec, 0);
        m_used = '0; m_hand = 2;

        // R6 directed: clean frame behind dirty unused ones
        do_reset();
        do_ref(0, 1); do_ref(1, 1);
        model_sweep(1);
        run_req(1, cyc);
        check_result("R6 clean pick", cyc);

        // Random mix of references and requests
        for (int it = 0; it < 60; it++) begin
            bit cl;
            int nref;
            if (it % 12 == 0) do_reset();
            nref = $urandom_range(0, 20);
            for (int j = 0; j < nref; j++)
                do_ref($urandom_range(0, N - 1), ($urandom_range(0, 3) == 0));
            cl = $urandom_range(0, 1);
            model_sweep(cl);
            run_req(cl, cyc);
            check_result(cl ? "R6 R7 random" : "R3 R10 random", cyc);
            chk("R2 random dirty", dirty_vec, m_dirty);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule